// File: doc/BRIEF.md
# Fast Link Pulse Burst Codec

This block turns a 16-bit link code word into a burst of link pulses on a single serial output, and recovers a code word from a stream of pulses on a detect input. A burst has 33 evenly spaced slots. Every even slot, counting from zero, carries a framing pulse that is always sent. Each odd slot carries one code word bit: a pulse means 1 and an empty slot means 0. The transmitter puts the IEEE 802.3 selector value into the five low bits of every word it sends.

The transmit side starts a burst on a one-cycle strobe and holds a busy flag until the last slot has elapsed. All timing is counted in clock cycles and set by parameters: the spacing between slots, the pulse width, the width of the acceptance window at the receiver, and the receive timeout. The receive side detects rising edges on its input. The first edge starts a burst. It then expects each data pulse near the mid-point between two framing pulses and each framing pulse one full period later. At the end of each burst it reports exactly one of three outcomes: a valid word, an error, or a short burst.

Top module: `flp_codec`

## Requirements
- R1: A burst contains all 17 framing pulses and one pulse for each 1 bit of the transmitted word. The total pulse count on `txPulse` is 17 plus the number of ones in the sent word.
- R2: The transmitter replaces bits 4:0 of `txWord` with 5'b00001 and keeps bits 15:5 as given.
- R3: Code word bits are sent LSB first. The pulse for bit k rises HALF_CYCLES after framing pulse k, and framing pulses are 2*HALF_CYCLES apart.
- R4: Every transmitted pulse is high for exactly PULSE_CYCLES cycles.
- R5: `txBusy` rises the cycle after an accepted `txStart` and stays high for 33*HALF_CYCLES cycles. A `txStart` seen while busy has no effect on the burst in progress and does not start another one.
- R6: A received burst of 17 well-timed framing pulses produces a one-cycle `rxValid` pulse. At the same time `rxWord` is loaded with the data bits, LSB first. The receiver does not force the selector bits.
- R7: A data pulse whose rising edge falls within WINDOW_CYCLES (inclusive) of the mid-point is decoded as a 1.
- R8: A rising edge outside every acceptance window produces `rxError` at the end of the burst and no `rxValid`. `rxWord` keeps its previous value.
- R9: If no framing pulse arrives within TIMEOUT_CYCLES of the previous one, and fewer than 17 framing pulses have been seen, the receiver produces `rxShort` and no `rxValid`. `rxWord` keeps its previous value.
- R10: Each received burst ends with exactly one of `rxValid`, `rxError` or `rxShort`, each high for a single cycle. At most one of the three is high in any cycle.
- R11: After reset, `txPulse`, `txBusy`, `rxValid`, `rxError` and `rxShort` are low and `rxWord` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | One-cycle request to send a burst |
| txWord | input | 16 | Code word to send |
| txBusy | output | 1 | High while a burst is being sent |
| txPulse | output | 1 | Serial pulse output |
| rxPulseIn | input | 1 | Pulse-detect input |
| rxWord | output | 16 | Last code word received without fault |
| rxValid | output | 1 | One-cycle flag: a word was received |
| rxError | output | 1 | One-cycle flag: the burst held a mistimed pulse |
| rxShort | output | 1 | One-cycle flag: the burst ended before 17 framing pulses |

## Verification
A loopback from the transmitter cannot produce mistimed or missing pulses, so the receiver's fault paths cannot be reached that way. The bench therefore switches the receive input to its own pulse generator. This generator builds a burst cycle by cycle from a word, a framing-pulse count and a data-pulse offset. With it the bench places data edges exactly on both window limits and one cycle outside them, and cuts bursts short to force the timeout. After each faulty burst it checks that the previously received word is still on `rxWord`.

// File: rtl/flp_pkg.sv
package flp_pkg;

  localparam int unsigned FLP_SLOTS  = 33;
  localparam int unsigned FLP_FRAMES = 17;
  localparam int unsigned FLP_BITS   = 16;
  localparam logic [4:0]  FLP_SELECTOR = 5'b00001;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic txLoad;    // capture a new word
    logic txFire;    // launch one pulse
    logic txShift;   // a data slot was consumed
    logic rxShift;   // a framing pulse closed a bit cell
    logic rxBit;     // value of that bit cell
    logic rxCommit;  // publish the assembled word
  } flpStrobe_t;

endpackage

// File: rtl/flp_ctrl.sv
module flp_ctrl
  import flp_pkg::*;
#(
  parameter int unsigned HALF_CYCLES    = 6250,
  parameter int unsigned WINDOW_CYCLES  = 800,
  parameter int unsigned TIMEOUT_CYCLES = 2 * HALF_CYCLES + 2 * WINDOW_CYCLES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txStart,
  input  logic       pulseIn,
  input  logic       txBit,
  output flpStrobe_t strb,
  output logic       txBusy,
  output logic       rxValid,
  output logic       rxError,
  output logic       rxShort
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYCLES - 1);
  localparam logic [CNT_W-1:0] DATA_LO   = CNT_W'(HALF_CYCLES - WINDOW_CYCLES);
  localparam logic [CNT_W-1:0] DATA_HI   = CNT_W'(HALF_CYCLES + WINDOW_CYCLES);
  localparam logic [CNT_W-1:0] FRAME_LO  = CNT_W'(2 * HALF_CYCLES - WINDOW_CYCLES);
  localparam logic [CNT_W-1:0] FRAME_HI  = CNT_W'(2 * HALF_CYCLES + WINDOW_CYCLES);
  localparam logic [CNT_W-1:0] TIMEOUT_V = CNT_W'(TIMEOUT_CYCLES);
  localparam logic [5:0] SLOT_LAST  = 6'(FLP_SLOTS - 1);
  localparam logic [4:0] FRAME_LAST = 5'(FLP_FRAMES - 1);

  // ---------------- transmit sequencing ----------------
  logic [CNT_W-1:0] txCnt;
  logic [5:0]       txSlot;
  logic             slotTick, txLast;

  always_comb begin
    slotTick = txBusy && (txCnt == '0);
    txLast   = txBusy && (txCnt == HALF_LAST) && (txSlot == SLOT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
      txSlot <= '0;
    end else if (!txBusy) begin
      if (txStart) begin
        txBusy <= 1'b1;
        txCnt  <= '0;
        txSlot <= '0;
      end
    end else if (txCnt == HALF_LAST) begin
      txCnt <= '0;
      if (txSlot == SLOT_LAST) txBusy <= 1'b0;
      else                     txSlot <= txSlot + 6'd1;
    end else begin
      txCnt <= txCnt + 1'b1;
    end
  end

  // ---------------- receive tracking ----------------
  logic             rxPrev, rxActive, gotData, badSeen;
  logic [CNT_W-1:0] rxTimer;
  logic [4:0]       frameCnt;
  logic             rise, inData, inFrame;
  logic             frameHit, dataHit, stray, timeoutHit, lastFrame;

  always_comb begin
    rise       = pulseIn && !rxPrev;
    inData     = (rxTimer >= DATA_LO) && (rxTimer <= DATA_HI);
    inFrame    = (rxTimer >= FRAME_LO) && (rxTimer <= FRAME_HI);
    timeoutHit = rxActive && (rxTimer == TIMEOUT_V);
    frameHit   = rxActive && !timeoutHit && rise && inFrame;
    dataHit    = rxActive && !timeoutHit && rise && inData && !gotData;
    stray      = rxActive && !timeoutHit && rise && !frameHit && !dataHit;
    lastFrame  = frameHit && (frameCnt == FRAME_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPrev   <= 1'b0;
      rxActive <= 1'b0;
      gotData  <= 1'b0;
      badSeen  <= 1'b0;
      rxTimer  <= '0;
      frameCnt <= '0;
      rxValid  <= 1'b0;
      rxError  <= 1'b0;
      rxShort  <= 1'b0;
    end else begin
      rxPrev  <= pulseIn;
      rxValid <= 1'b0;
      rxError <= 1'b0;
      rxShort <= 1'b0;
      if (!rxActive) begin
        if (rise) begin
          rxActive <= 1'b1;
          rxTimer  <= CNT_W'(1);
          frameCnt <= 5'd1;
          gotData  <= 1'b0;
          badSeen  <= 1'b0;
        end
      end else if (timeoutHit) begin
        rxActive <= 1'b0;
        rxError  <= badSeen;
        rxShort  <= !badSeen;
      end else begin
        rxTimer <= rxTimer + 1'b1;
        if (dataHit) gotData <= 1'b1;
        if (stray)   badSeen <= 1'b1;
        if (frameHit) begin
          rxTimer  <= CNT_W'(1);
          gotData  <= 1'b0;
          frameCnt <= frameCnt + 5'd1;
          if (lastFrame) begin
            rxActive <= 1'b0;
            rxValid  <= !badSeen;
            rxError  <= badSeen;
          end
        end
      end
    end
  end

  always_comb begin
    strb.txLoad   = !txBusy && txStart;
    strb.txFire   = slotTick && (!txSlot[0] || txBit);
    strb.txShift  = slotTick && txSlot[0];
    strb.rxShift  = frameHit;
    strb.rxBit    = gotData;
    strb.rxCommit = lastFrame && !badSeen;
  end

  // R5: once running, only the final slot ends the burst
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !txLast) |=> txBusy);

  // R5: an idle transmitter given a start becomes busy next cycle
  a_r5_start_accepted: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && txStart) |=> txBusy);

  // R10: outcome flags never coincide
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid, rxError, rxShort}));

  // R6: an active burst never counts past the last framing pulse
  a_r6_frames_bounded: assert property (@(posedge clk) disable iff (!rstN)
    rxActive |-> (frameCnt >= 5'd1 && frameCnt <= FRAME_LAST));

  // R10: a publish strobe is always followed by a valid flag
  a_r10_commit_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxCommit |=> rxValid);

endmodule

// File: rtl/flp_datapath.sv
module flp_datapath
  import flp_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  flpStrobe_t          strb,
  input  logic [FLP_BITS-1:0] txWord,
  output logic                txBit,
  output logic                txPulse,
  output logic [FLP_BITS-1:0] rxWord
);

  localparam int unsigned PW_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [FLP_BITS-1:0] SEL_MASK = FLP_BITS'(5'h1F);
  localparam logic [FLP_BITS-1:0] SEL_VAL  = FLP_BITS'(FLP_SELECTOR);

  logic [FLP_BITS-1:0] txSh, rxSh;
  logic [PW_W-1:0]     widthCnt;

  // outgoing word, selector field forced
  always_ff @(posedge clk) begin
    if (!rstN)              txSh <= '0;
    else if (strb.txLoad)   txSh <= (txWord & ~SEL_MASK) | SEL_VAL;
    else if (strb.txShift)  txSh <= {1'b0, txSh[FLP_BITS-1:1]};
  end
  assign txBit = txSh[0];

  // single pulse-width timer for every pulse of the burst
  always_ff @(posedge clk) begin
    if (!rstN)                widthCnt <= '0;
    else if (strb.txFire)     widthCnt <= PW_W'(PULSE_CYCLES);
    else if (widthCnt != '0)  widthCnt <= widthCnt - 1'b1;
  end
  assign txPulse = (widthCnt != '0);

  // incoming bits enter at the top so the first one ends at bit 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh   <= '0;
      rxWord <= '0;
    end else begin
      if (strb.rxShift)  rxSh   <= {strb.rxBit, rxSh[FLP_BITS-1:1]};
      if (strb.rxCommit) rxWord <= {strb.rxBit, rxSh[FLP_BITS-1:1]};
    end
  end

  // R4: a new pulse is only launched after the previous one has finished
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    strb.txFire |-> (widthCnt == '0));

  // R4: the timer is reloaded to its full width by each launch
  a_r4_full_width: assert property (@(posedge clk) disable iff (!rstN)
    strb.txFire |=> (widthCnt == PW_W'(PULSE_CYCLES)));

  // R8: the published word changes only on a commit strobe
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxCommit |=> $stable(rxWord));

endmodule

// File: rtl/flp_codec.sv
module flp_codec
  import flp_pkg::*;
#(
  parameter int unsigned HALF_CYCLES    = 6250,
  parameter int unsigned PULSE_CYCLES   = 10,
  parameter int unsigned WINDOW_CYCLES  = 800,
  parameter int unsigned TIMEOUT_CYCLES = 2 * HALF_CYCLES + 2 * WINDOW_CYCLES
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txStart,
  input  logic [15:0] txWord,
  output logic        txBusy,
  output logic        txPulse,
  input  logic        rxPulseIn,
  output logic [15:0] rxWord,
  output logic        rxValid,
  output logic        rxError,
  output logic        rxShort
);

  flpStrobe_t strb;
  logic       txBit;

  flp_ctrl #(
    .HALF_CYCLES   (HALF_CYCLES),
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .txStart (txStart),
    .pulseIn (rxPulseIn),
    .txBit   (txBit),
    .strb    (strb),
    .txBusy  (txBusy),
    .rxValid (rxValid),
    .rxError (rxError),
    .rxShort (rxShort)
  );

  flp_datapath #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txWord  (txWord),
    .txBit   (txBit),
    .txPulse (txPulse),
    .rxWord  (rxWord)
  );

endmodule

// File: tb/tb_flp_codec.sv
module tb_flp_codec;

  localparam int HALF = 20;
  localparam int PW   = 3;
  localparam int WIN  = 4;
  localparam int TOUT = 2 * HALF + 2 * WIN;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txStart = 1'b0;
  logic [15:0] txWord = '0;
  logic        txBusy, txPulse, rxValid, rxError, rxShort;
  logic [15:0] rxWord;
  logic        loopSel = 1'b1;
  logic        benchPulse = 1'b0;
  logic        rxIn;

  assign rxIn = loopSel ? txPulse : benchPulse;

  always #5 clk = ~clk;

  flp_codec #(
    .HALF_CYCLES(HALF), .PULSE_CYCLES(PW),
    .WINDOW_CYCLES(WIN), .TIMEOUT_CYCLES(TOUT)
  ) dut (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txWord(txWord),
    .txBusy(txBusy), .txPulse(txPulse), .rxPulseIn(rxIn),
    .rxWord(rxWord), .rxValid(rxValid), .rxError(rxError), .rxShort(rxShort)
  );

  int checks = 0;
  int errors = 0;

  // monitor, sampled on the falling edge
  int cyc = 0, riseCnt = 0, firstRise = 0, secondRise = 0;
  int busyCyc = 0, run = 0, badWidth = 0;
  int nValid = 0, nError = 0, nShort = 0, multiFlag = 0;
  logic prevTx = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (txBusy) busyCyc++;
    if (txPulse && !prevTx) begin
      riseCnt++;
      if (riseCnt == 1) firstRise = cyc;
      if (riseCnt == 2) secondRise = cyc;
    end
    if (txPulse) run++;
    else if (run != 0) begin
      if (run != PW) badWidth++;
      run = 0;
    end
    prevTx = txPulse;
    if (rxValid) nValid++;
    if (rxError) nError++;
    if (rxShort) nShort++;
    if (int'(rxValid) + int'(rxError) + int'(rxShort) > 1) multiFlag++;
  end

  task automatic clearMon();
    riseCnt = 0; firstRise = 0; secondRise = 0; busyCyc = 0; badWidth = 0;
    nValid = 0; nError = 0; nShort = 0; multiFlag = 0;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendTx(logic [15:0] w);
    @(negedge clk);
    txWord = w; txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && txBusy; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // builds a receive burst cycle by cycle
  task automatic genBurst(logic [15:0] w, int frames, int off);
    int total;
    total = (frames - 1) * 2 * HALF + PW + 1;
    for (int c = 0; c < total; c++) begin
      int f, pos;
      logic hi;
      @(negedge clk);
      f = c / (2 * HALF);
      pos = c % (2 * HALF);
      hi = (f < frames) && (pos < PW);
      if (f < frames - 1 && f < 16 && w[f] &&
          pos >= HALF + off && pos < HALF + off + PW) hi = 1'b1;
      benchPulse = hi;
    end
    @(negedge clk);
    benchPulse = 1'b0;
    repeat (TOUT + 10) @(negedge clk);
  endtask

  // stimulus word in the top half, expected sent word in the bottom half
  localparam logic [31:0] TX_VEC [6] = '{
    32'h0000_0001, 32'hFFFF_FFE1, 32'hA5A5_A5A1,
    32'h1234_1221, 32'h8001_8001, 32'h7FE0_7FE1
  };

  initial begin
    // R11: reset state
    repeat (5) @(negedge clk);
    check("R11 txPulse", int'(txPulse), 0);
    check("R11 txBusy", int'(txBusy), 0);
    check("R11 rx flags", int'({rxValid, rxError, rxShort}), 0);
    check("R11 rxWord", int'(rxWord), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // loopback vector walk: R1 R2 R3 R4 R5 R6 R10
    foreach (TX_VEC[i]) begin
      logic [15:0] stim, expw;
      stim = TX_VEC[i][31:16];
      expw = TX_VEC[i][15:0];
      clearMon();
      sendTx(stim);
      waitIdle();
      check("R1 pulse count", riseCnt, 17 + $countones(expw));
      check("R2/R6 decoded word", int'(rxWord), int'(expw));
      check("R3 data slot offset", secondRise - firstRise, HALF);
      check("R4 pulse widths", badWidth, 0);
      check("R5 busy length", busyCyc, 33 * HALF);
      check("R10 single valid", nValid + 16 * (nError + nShort + multiFlag), 1);
    end

    // R5: start while busy is ignored
    clearMon();
    sendTx(16'h0F00);
    repeat (100) @(negedge clk);
    txWord = 16'hFFFF; txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    waitIdle();
    check("R5 busy length with extra start", busyCyc, 33 * HALF);
    check("R5 first word kept", int'(rxWord), 16'h0F01);
    check("R5 pulse count of first word", riseCnt, 17 + 5);
    repeat (50) @(negedge clk);
    check("R5 no second burst", int'(txBusy), 0);
    check("R5 no extra pulses", riseCnt, 17 + 5);

    // receive side from the bench generator
    loopSel = 1'b0;

    clearMon();
    genBurst(16'hC3A6, 17, WIN);
    check("R7 late edge accepted", int'(rxWord), 16'hC3A6);
    check("R6 valid once", nValid, 1);

    clearMon();
    genBurst(16'h5A0F, 17, -WIN);
    check("R7 early edge accepted", int'(rxWord), 16'h5A0F);
    check("R10 valid only", nValid * 100 + nError * 10 + nShort, 100);

    clearMon();
    genBurst(16'hFFFF, 17, WIN + 1);
    check("R8 late error flagged", nError, 1);
    check("R8 no valid", nValid + nShort, 0);
    check("R8 word held", int'(rxWord), 16'h5A0F);

    clearMon();
    genBurst(16'h0101, 17, -WIN - 1);
    check("R8 early error flagged", nError, 1);
    check("R8 word held early", int'(rxWord), 16'h5A0F);

    clearMon();
    genBurst(16'h0F0F, 10, 0);
    check("R9 short flagged", nShort, 1);
    check("R9 no valid or error", nValid + nError, 0);
    check("R9 word held", int'(rxWord), 16'h5A0F);

    clearMon();
    genBurst(16'h8421, 17, 0);
    check("R6 recovery word", int'(rxWord), 16'h8421);
    check("R10 recovery outcome", nValid * 100 + nError * 10 + nShort, 100);
    check("R10 no overlap", multiFlag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule